// File: doc/BRIEF.md
# Hot-Plug Link Reset Controller

This block watches one serial storage link for devices being plugged in and pulled out. It has two states. In the probing state it sends link-reset requests to the far end at a fixed long interval until a device answers. In the ready state the link carries normal traffic. A line-silence watchdog notices when a connected device vanishes and forces the block back to probing. Each time the ready status changes, in either direction, the block sets a sticky change flag. The flag reaches the host as an interrupt only when software has enabled it.

All inputs and outputs are plain control and status pins. No data moves through the block, so there is no valid/ready stream and no back-pressure. The retry period and the silence limit are parameters given in clock cycles. The defaults match 100 ms and 200 ns at 50 MHz, and a bench can shrink them. The change flag is write-one-to-clear, through a single-cycle clear strobe.

Top module: `hotplug_link_fsm`

## Requirements
- R1: While reset is held, `link_reset_o`, `phy_rdy_o`, `chg_flag_o` and `irq_o` are all 0.
- R2: In the first clock cycle after reset is released, the block issues one link-reset strobe (`link_reset_o` = 1).
- R3: `link_reset_o` is high for exactly one cycle per request and only while in the probing state (`phy_rdy_o` = 0). In probing with retries active, consecutive strobes are exactly RETRY_CYCLES cycles apart.
- R4: A pulse on `init_seen_i` while probing stops further strobes, for as long as the line stays active. Once the line has been silent for SILENCE_CYCLES cycles, strobes resume.
- R5: In probing, with `phy_rdy_i` = 1 and the line not timed out, `phy_rdy_o` rises one cycle later. No strobes are issued in the ready state.
- R6: In the ready state, `phy_rdy_i` = 0 makes `phy_rdy_o` fall one cycle later. A new strobe follows in the very next cycle.
- R7: With `phy_rdy_i` held at 1, SILENCE_CYCLES consecutive cycles with `line_active_i` = 0 make `phy_rdy_o` fall one cycle after the last of them. `phy_rdy_o` stays 0 while the line remains silent. Once the line is active again, it returns to 1 two cycles later.
- R8: Every change of `phy_rdy_o`, rising or falling, sets `chg_flag_o` in the same cycle.
- R9: A pulse on `chg_clr_i` clears `chg_flag_o` one cycle later. If a new change occurs in the same cycle as the clear, the flag stays set.
- R10: `irq_o` is 1 exactly when both `chg_flag_o` and `irq_en_i` are 1. It follows `irq_en_i` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_active_i | input | 1 | Valid signalling seen on the line this cycle |
| init_seen_i | input | 1 | Device init response detected |
| phy_rdy_i | input | 1 | PHY-ready indication from the link layer |
| chg_clr_i | input | 1 | Write-one-to-clear strobe for the change flag |
| irq_en_i | input | 1 | Enable for the change interrupt |
| link_reset_o | output | 1 | Single-cycle link-reset request strobe |
| phy_rdy_o | output | 1 | Ready status (1 = ready state) |
| chg_flag_o | output | 1 | Sticky ready-change flag |
| irq_o | output | 1 | Change interrupt toward the host |

## Verification
The retry path is tried with the line idle, then with an init response held while the line is active, then with the line falling silent. These runs separate free-running retries, suppressed retries and resumed retries. The exit from the ready state is driven two ways: by dropping `phy_rdy_i` while the line is active, and by silencing the line while `phy_rdy_i` stays high. Both must lead to the same state, but they differ in timing, and only the silent case must not bounce back to ready. The change flag is exercised with a clear alone and with a clear that lands on a transition edge, which shows whether set has priority over clear. The interrupt is checked with the enable both off and on.

// File: rtl/hotplug_pkg.sv
package hotplug_pkg;
  typedef enum logic {
    ST_PROBE = 1'b0,
    ST_READY = 1'b1
  } link_st_e;
endpackage

// File: rtl/hp_retry_timer.sv
module hp_retry_timer #(
  parameter int unsigned RETRY_CYCLES = 5_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic fire_o
);
  localparam int unsigned CW = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(RETRY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  // A zero count means a strobe is due; after each strobe the count reloads.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (restart_i) begin
        cnt_q <= '0;
      end else if (run_i) begin
        if (cnt_q == '0) begin
          fire_o <= 1'b1;
          cnt_q  <= RELOAD;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // R3
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/hp_silence_wd.sv
module hp_silence_wd #(
  parameter int unsigned SILENCE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic timeout_o
);
  localparam int unsigned SW = $clog2(SILENCE_CYCLES + 1);
  localparam logic [SW-1:0] LIMIT = SW'(SILENCE_CYCLES);

  logic [SW-1:0] quiet_q;

  // Counts consecutive quiet cycles and saturates at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= '0;
    end else if (active_i) begin
      quiet_q <= '0;
    end else if (quiet_q != LIMIT) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assign timeout_o = (quiet_q == LIMIT);

  // R7
  activity_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |=> !timeout_o);
endmodule

// File: rtl/hp_change_flag.sv
module hp_change_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  // A new change wins over a clear that arrives in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  assign irq_o = flag_o & en_i;

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !irq_o);
endmodule

// File: rtl/hotplug_link_fsm.sv
module hotplug_link_fsm
  import hotplug_pkg::*;
#(
  parameter int unsigned RETRY_CYCLES   = 5_000_000,
  parameter int unsigned SILENCE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_active_i,
  input  logic init_seen_i,
  input  logic phy_rdy_i,
  input  logic chg_clr_i,
  input  logic irq_en_i,
  output logic link_reset_o,
  output logic phy_rdy_o,
  output logic chg_flag_o,
  output logic irq_o
);
  link_st_e state_q, state_d;
  logic     timeout;
  logic     hold_q;
  logic     enter_probe;
  logic     retry_run;

  hp_silence_wd #(.SILENCE_CYCLES(SILENCE_CYCLES)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (line_active_i),
    .timeout_o (timeout)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PROBE: if (phy_rdy_i && !timeout)  state_d = ST_READY;
      ST_READY: if (!phy_rdy_i || timeout)  state_d = ST_PROBE;
      default:                               state_d = ST_PROBE;
    endcase
  end

  assign enter_probe = (state_q == ST_READY) && (state_d == ST_PROBE);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_PROBE;
    else        state_q <= state_d;
  end

  // An init response parks the retries until the line goes quiet again.
  always_ff @(posedge clk) begin
    if (!rst_n)                                 hold_q <= 1'b0;
    else if (state_q != ST_PROBE)               hold_q <= 1'b0;
    else if (init_seen_i)                       hold_q <= 1'b1;
    else if (timeout)                           hold_q <= 1'b0;
  end

  assign retry_run = (state_q == ST_PROBE) && (state_d == ST_PROBE)
                   && !hold_q && !init_seen_i;

  hp_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (enter_probe),
    .run_i     (retry_run),
    .fire_o    (link_reset_o)
  );

  assign phy_rdy_o = (state_q == ST_READY);

  hp_change_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (state_d != state_q),
    .clr_i  (chg_clr_i),
    .en_i   (irq_en_i),
    .flag_o (chg_flag_o),
    .irq_o  (irq_o)
  );

  // R3
  strobe_only_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_reset_o |-> !phy_rdy_o);

  // R8
  change_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rdy_o != $past(phy_rdy_o)) |-> chg_flag_o);

  // R7
  silent_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !phy_rdy_o) |=> !phy_rdy_o);
endmodule

// File: tb/tb_hotplug_link_fsm.sv
module tb_hotplug_link_fsm;
  localparam int RETRY = 20;
  localparam int SIL   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_active_i = 1'b0, init_seen_i = 1'b0, phy_rdy_i = 1'b0;
  logic chg_clr_i = 1'b0, irq_en_i = 1'b0;
  logic link_reset_o, phy_rdy_o, chg_flag_o, irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hotplug_link_fsm #(.RETRY_CYCLES(RETRY), .SILENCE_CYCLES(SIL)) dut (
    .clk(clk), .rst_n(rst_n), .line_active_i(line_active_i),
    .init_seen_i(init_seen_i), .phy_rdy_i(phy_rdy_i), .chg_clr_i(chg_clr_i),
    .irq_en_i(irq_en_i), .link_reset_o(link_reset_o), .phy_rdy_o(phy_rdy_o),
    .chg_flag_o(chg_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk("R1", "link_reset_o", link_reset_o, 0);
    chk("R1", "phy_rdy_o", phy_rdy_o, 0);
    chk("R1", "chg_flag_o", chg_flag_o, 0);
    chk("R1", "irq_o", irq_o, 0);
  endtask

  task automatic t_powerup_and_period();
    int n;
    rst_n = 1'b1;
    step();
    chk("R2", "first strobe", link_reset_o, 1);
    n = 0;
    for (int i = 0; i < 3 * RETRY; i++) begin
      step();
      n++;
      if (i == 0) chk("R3", "strobe width", link_reset_o, 0);
      if (link_reset_o) break;
    end
    chk("R3", "retry period", n, RETRY);
  endtask

  task automatic t_init_hold();
    int pulses;
    int seen;
    line_active_i = 1'b1;
    init_seen_i = 1'b1;
    step();
    init_seen_i = 1'b0;
    pulses = 0;
    for (int i = 0; i < 2 * RETRY; i++) begin
      step();
      pulses += int'(link_reset_o);
    end
    chk("R4", "strobes while held", pulses, 0);
    line_active_i = 1'b0;
    seen = 0;
    for (int i = 0; i < SIL + RETRY + 4; i++) begin
      step();
      if (link_reset_o) seen = 1;
    end
    chk("R4", "strobes resume after silence", seen, 1);
  endtask

  task automatic t_ready_and_irq();
    int pulses;
    line_active_i = 1'b1;
    repeat (2) step();
    phy_rdy_i = 1'b1;
    step();
    chk("R5", "phy_rdy_o rises", phy_rdy_o, 1);
    chk("R8", "flag on rise", chg_flag_o, 1);
    chk("R10", "irq masked", irq_o, 0);
    irq_en_i = 1'b1;
    #1;
    chk("R10", "irq enabled", irq_o, 1);
    chg_clr_i = 1'b1;
    step();
    chg_clr_i = 1'b0;
    chk("R9", "flag cleared", chg_flag_o, 0);
    chk("R10", "irq after clear", irq_o, 0);
    pulses = 0;
    for (int i = 0; i < RETRY + 2; i++) begin
      step();
      pulses += int'(link_reset_o);
    end
    chk("R5", "no strobes when ready", pulses, 0);
  endtask

  task automatic t_drop();
    phy_rdy_i = 1'b0;
    step();
    chk("R6", "phy_rdy_o falls", phy_rdy_o, 0);
    chk("R8", "flag on fall", chg_flag_o, 1);
    step();
    chk("R6", "strobe after entry", link_reset_o, 1);
  endtask

  task automatic t_set_beats_clear();
    phy_rdy_i = 1'b1;
    chg_clr_i = 1'b1;
    step();
    chg_clr_i = 1'b0;
    chk("R9", "ready again", phy_rdy_o, 1);
    chk("R9", "set wins over clear", chg_flag_o, 1);
    chg_clr_i = 1'b1;
    step();
    chg_clr_i = 1'b0;
  endtask

  task automatic t_silence();
    int bounced;
    line_active_i = 1'b0;
    repeat (SIL) step();
    chk("R7", "ready before limit", phy_rdy_o, 1);
    step();
    chk("R7", "dropped at limit", phy_rdy_o, 0);
    chk("R8", "flag on silence drop", chg_flag_o, 1);
    bounced = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      bounced += int'(phy_rdy_o);
    end
    chk("R7", "no bounce while silent", bounced, 0);
    line_active_i = 1'b1;
    repeat (2) step();
    chk("R7", "ready after activity", phy_rdy_o, 1);
  endtask

  initial begin
    t_reset();
    t_powerup_and_period();
    t_init_hold();
    t_ready_and_irq();
    t_drop();
    t_set_beats_clear();
    t_silence();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule